// File: doc/BRIEF.md
# Modem Handshake Controller with Status-Change Detection

This block manages the modem handshake lines of one serial channel. It takes three active-low status lines from the modem side: carrier present, clear to send and a general sync/status input. It drives two active-low control lines: request to send and terminal ready. Each status line passes through a two-flop synchronizer. It then goes through a width filter that accepts a new level only after the level has held for a programmable number of system clocks. Accepted levels are latched into status bits. When enabled, a change raises an interrupt request that stays pending until the host issues a clear command.

The filtered carrier and clear-to-send levels also produce run qualifiers for the receiver and the transmitter. When auto-enable is selected, each shifter may run only while its line is asserted. In asynchronous mode, request to send turns on at once. When commanded off, it stays on until the transmitter reports that it is fully drained, shift register included. In synchronous mode it follows its command bit directly.

Top module: `mdm_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the following values are set after that edge: `rts_n` and `dtr_n` are 1, `irq` is 0, all three status bits are 0, and `rx_run_ok` and `tx_run_ok` are 0.
- R2: A status line driven low for at least MIN_W consecutive clocks is accepted. A low pulse shorter than MIN_W clocks leaves the status bits and `irq` unchanged.
- R3: When a line falls before clock edge 1, the accepted change is visible on `irq` and on the status bit after edge MIN_W+3, and not before.
- R4: A status bit reads 1 while its filtered line is low (asserted). With `int_en` high, an accepted change on carrier or clear-to-send sets `irq`.
- R5: While `irq` is pending, it stays high and all status bits hold their values. A clock with `stat_clr` high clears `irq`, taking priority over new changes. Once pending is clear, the status bits reload the filtered levels.
- R6: With `int_en` low, the status bits follow the filtered levels and `irq` is never raised.
- R7: An accepted change on the sync input raises `irq` only when `mode_async` is 1. With `mode_async` at 0, its status bit still updates but `irq` stays low.
- R8: `rx_run_ok` is 1 one clock after `rx_auto_en` is 0. Otherwise it equals the filtered carrier-asserted level, with one clock of delay.
- R9: `tx_run_ok` is 1 one clock after `tx_auto_en` is 0. Otherwise it equals the filtered clear-to-send-asserted level, with one clock of delay.
- R10: With `mode_async` = 1, `rts_cmd` = 1 drives `rts_n` low after the next clock edge.
- R11: With `mode_async` = 1 and `rts_cmd` = 0, `rts_n` keeps its previous value while `tx_empty` is 0, and goes high after the edge at which `tx_empty` is 1.
- R12: With `mode_async` = 0, `rts_n` is the inverse of `rts_cmd` one clock later, regardless of `tx_empty`.
- R13: `dtr_n` is the inverse of `dtr_cmd` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dcd_n | input | 1 | Carrier detect line, low = asserted |
| cts_n | input | 1 | Clear-to-send line, low = asserted |
| sync_n | input | 1 | Sync/general status line, low = asserted |
| mode_async | input | 1 | 1 = asynchronous mode, 0 = synchronous modes |
| rts_cmd | input | 1 | Request-to-send command bit |
| dtr_cmd | input | 1 | Terminal-ready command bit |
| tx_empty | input | 1 | Transmitter fully drained, shift register included |
| int_en | input | 1 | Status-change interrupt enable |
| rx_auto_en | input | 1 | Gate receiver on carrier |
| tx_auto_en | input | 1 | Gate transmitter on clear to send |
| stat_clr | input | 1 | Reset-status command, one clock per write |
| rts_n | output | 1 | Request to send, low = active |
| dtr_n | output | 1 | Terminal ready, low = active |
| stat_dcd | output | 1 | Latched carrier status, 1 = asserted |
| stat_cts | output | 1 | Latched clear-to-send status, 1 = asserted |
| stat_sync | output | 1 | Latched sync-line status, 1 = asserted |
| irq | output | 1 | Status-change interrupt request |
| rx_run_ok | output | 1 | Receiver may run |
| tx_run_ok | output | 1 | Transmitter may run |

## Verification
The width filter is swept with low pulses of every length from one clock up to two past the minimum. This sweep separates the accepted case from the rejected case exactly at the threshold. The edge-to-interrupt delay is also pinned to a single cycle. The request-to-send logic is driven through every combination of mode, command, drain flag and previous output level, which tells deferred release apart from direct following. Separate patterns show four more behaviours: the status bits stay frozen while an interrupt is pending, interrupts stay silent when disabled, the sync line is gated by mode, and each run qualifier follows its line under auto-enable.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int unsigned N_STAT  = 3;
  localparam int unsigned IDX_DCD = 0;
  localparam int unsigned IDX_CTS = 1;
  localparam int unsigned IDX_SYN = 2;

  typedef enum logic {
    MODE_SYNC  = 1'b0,
    MODE_ASYNC = 1'b1
  } mdm_mode_e;
endpackage

// File: rtl/mdm_sync2.sv
module mdm_sync2 #(
  parameter int unsigned W       = 1,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= {W{RST_VAL}};
      q    <= {W{RST_VAL}};
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/mdm_width_filter.sv
module mdm_width_filter #(
  parameter int unsigned MIN_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic act_i,
  output logic lvl_o
);
  localparam int unsigned CW = (MIN_W < 2) ? 1 : $clog2(MIN_W + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_W - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      lvl_o <= 1'b0;
    end else if (act_i == lvl_o) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      lvl_o <= act_i;
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdm_rts_ctl.sv
module mdm_rts_ctl
  import mdm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mode_async,
  input  logic rts_cmd,
  input  logic tx_empty,
  input  logic dtr_cmd,
  output logic rts_n,
  output logic dtr_n
);
  mdm_mode_e mode;
  logic      rts_nxt;

  assign mode = mdm_mode_e'(mode_async);

  always_comb begin
    unique case (mode)
      MODE_ASYNC: begin
        if (rts_cmd)       rts_nxt = 1'b1;
        else if (tx_empty) rts_nxt = 1'b0;
        else               rts_nxt = ~rts_n;
      end
      default: rts_nxt = rts_cmd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rts_n <= 1'b1;
      dtr_n <= 1'b1;
    end else begin
      rts_n <= ~rts_nxt;
      dtr_n <= ~dtr_cmd;
    end
  end
endmodule

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
  import mdm_pkg::*;
#(
  parameter int unsigned MIN_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic dcd_n,
  input  logic cts_n,
  input  logic sync_n,
  input  logic mode_async,
  input  logic rts_cmd,
  input  logic dtr_cmd,
  input  logic tx_empty,
  input  logic int_en,
  input  logic rx_auto_en,
  input  logic tx_auto_en,
  input  logic stat_clr,
  output logic rts_n,
  output logic dtr_n,
  output logic stat_dcd,
  output logic stat_cts,
  output logic stat_sync,
  output logic irq,
  output logic rx_run_ok,
  output logic tx_run_ok
);
  logic [N_STAT-1:0] line_n;
  logic [N_STAT-1:0] line_s;
  logic [N_STAT-1:0] filt;
  logic [N_STAT-1:0] stat;
  logic [N_STAT-1:0] chg_mask;
  logic [N_STAT-1:0] chg;
  logic              pend;

  always_comb begin
    line_n          = '1;
    line_n[IDX_DCD] = dcd_n;
    line_n[IDX_CTS] = cts_n;
    line_n[IDX_SYN] = sync_n;
  end

  mdm_sync2 #(.W(N_STAT), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (line_n),
    .q   (line_s)
  );

  for (genvar i = 0; i < N_STAT; i++) begin : g_filt
    mdm_width_filter #(.MIN_W(MIN_W)) u_filt (
      .clk   (clk),
      .rst   (rst),
      .act_i (~line_s[i]),
      .lvl_o (filt[i])
    );
  end

  always_comb begin
    chg_mask          = '1;
    chg_mask[IDX_SYN] = mode_async;
    chg               = (filt ^ stat) & chg_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      pend <= 1'b0;
    end else begin
      if (stat_clr)                    pend <= 1'b0;
      else if (!pend && int_en && |chg) pend <= 1'b1;
      if (!pend) stat <= filt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_run_ok <= 1'b0;
      tx_run_ok <= 1'b0;
    end else begin
      rx_run_ok <= ~rx_auto_en | filt[IDX_DCD];
      tx_run_ok <= ~tx_auto_en | filt[IDX_CTS];
    end
  end

  mdm_rts_ctl u_rts (
    .clk        (clk),
    .rst        (rst),
    .mode_async (mode_async),
    .rts_cmd    (rts_cmd),
    .tx_empty   (tx_empty),
    .dtr_cmd    (dtr_cmd),
    .rts_n      (rts_n),
    .dtr_n      (dtr_n)
  );

  assign stat_dcd  = stat[IDX_DCD];
  assign stat_cts  = stat[IDX_CTS];
  assign stat_sync = stat[IDX_SYN];
  assign irq       = pend;
endmodule

// File: rtl/mdm_ctrl_chk.sv
module mdm_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic mode_async,
  input logic rts_cmd,
  input logic dtr_cmd,
  input logic tx_empty,
  input logic int_en,
  input logic tx_auto_en,
  input logic stat_clr,
  input logic rts_n,
  input logic dtr_n,
  input logic stat_dcd,
  input logic stat_cts,
  input logic stat_sync,
  input logic irq,
  input logic tx_run_ok
);
  a_r10_async_rts_on: assert property (@(posedge clk) disable iff (rst)
    (mode_async && rts_cmd) |=> !rts_n);

  a_r11_rts_held_until_empty: assert property (@(posedge clk) disable iff (rst)
    (mode_async && !rts_cmd && !tx_empty && !rts_n) |=> !rts_n);

  a_r12_sync_rts_follows: assert property (@(posedge clk) disable iff (rst)
    (!mode_async) |=> (rts_n == !$past(rts_cmd)));

  a_r13_dtr_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dtr_n == !$past(dtr_cmd)));

  a_r5_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (irq && !stat_clr) |=> irq);

  a_r5_stat_frozen: assert property (@(posedge clk) disable iff (rst)
    (irq && !stat_clr) |=> $stable({stat_sync, stat_cts, stat_dcd}));

  a_r5_clear_drops_irq: assert property (@(posedge clk) disable iff (rst)
    (irq && stat_clr) |=> !irq);

  a_r6_no_irq_when_disabled: assert property (@(posedge clk) disable iff (rst)
    (!int_en && !irq) |=> !irq);

  a_r9_tx_ok_without_auto: assert property (@(posedge clk) disable iff (rst)
    (!tx_auto_en) |=> tx_run_ok);
endmodule

bind mdm_ctrl mdm_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_async (mode_async),
  .rts_cmd    (rts_cmd),
  .dtr_cmd    (dtr_cmd),
  .tx_empty   (tx_empty),
  .int_en     (int_en),
  .tx_auto_en (tx_auto_en),
  .stat_clr   (stat_clr),
  .rts_n      (rts_n),
  .dtr_n      (dtr_n),
  .stat_dcd   (stat_dcd),
  .stat_cts   (stat_cts),
  .stat_sync  (stat_sync),
  .irq        (irq),
  .tx_run_ok  (tx_run_ok)
);

// File: tb/sim_mdm_ctrl.sv
`timescale 1ns/1ps
module sim_mdm_ctrl;
  localparam int MIN_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dcd_n = 1'b1, cts_n = 1'b1, sync_n = 1'b1;
  logic mode_async = 1'b1, rts_cmd = 1'b0, dtr_cmd = 1'b0, tx_empty = 1'b1;
  logic int_en = 1'b0, rx_auto_en = 1'b0, tx_auto_en = 1'b0, stat_clr = 1'b0;
  logic rts_n, dtr_n, stat_dcd, stat_cts, stat_sync, irq, rx_run_ok, tx_run_ok;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  mdm_ctrl #(.MIN_W(MIN_W)) u0 (
    .clk(clk), .rst(rst), .dcd_n(dcd_n), .cts_n(cts_n), .sync_n(sync_n),
    .mode_async(mode_async), .rts_cmd(rts_cmd), .dtr_cmd(dtr_cmd),
    .tx_empty(tx_empty), .int_en(int_en), .rx_auto_en(rx_auto_en),
    .tx_auto_en(tx_auto_en), .stat_clr(stat_clr), .rts_n(rts_n), .dtr_n(dtr_n),
    .stat_dcd(stat_dcd), .stat_cts(stat_cts), .stat_sync(stat_sync), .irq(irq),
    .rx_run_ok(rx_run_ok), .tx_run_ok(tx_run_ok)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // hold stat_clr for three clocks so status reloads with no new pending
  task automatic clear_status();
    stat_clr = 1'b1;
    tick(3);
    stat_clr = 1'b0;
    tick(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    // R1 reset state
    check("R1 reset outputs", {rts_n, dtr_n, irq, stat_dcd, stat_cts, stat_sync, rx_run_ok, tx_run_ok},
          8'b1100_0000);
    rst = 1'b0;
    tick(1);
    check("R9 tx_run_ok without auto-enable", {7'd0, tx_run_ok}, 8'd1);

    // R13 terminal ready
    dtr_cmd = 1'b1; tick(1);
    check("R13 dtr on", {7'd0, dtr_n}, 8'd0);
    dtr_cmd = 1'b0; tick(1);
    check("R13 dtr off", {7'd0, dtr_n}, 8'd1);

    // R10 R11 R12 sweep over mode, command, drain flag and previous output
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 8; c++) begin
        logic m, cm, e, exp_act;
        m = c[2]; cm = c[1]; e = c[0];
        mode_async = 1'b0; rts_cmd = p[0]; tick(1);
        mode_async = m; rts_cmd = cm; tx_empty = e; tick(1);
        if (!m)      exp_act = cm;
        else if (cm) exp_act = 1'b1;
        else if (e)  exp_act = 1'b0;
        else         exp_act = p[0];
        check(m ? (cm ? "R10 async rts on" : "R11 async rts release") : "R12 sync rts follows",
              {7'd0, rts_n}, {7'd0, ~exp_act});
      end
    end
    // R11 stays active for many clocks until drained
    mode_async = 1'b1; rts_cmd = 1'b1; tx_empty = 1'b0; tick(1);
    rts_cmd = 1'b0; tick(8);
    check("R11 rts held while not empty", {7'd0, rts_n}, 8'd0);
    tx_empty = 1'b1; tick(1);
    check("R11 rts released when empty", {7'd0, rts_n}, 8'd1);

    // R3 R4 R8 latency of an accepted carrier change
    int_en = 1'b1; rx_auto_en = 1'b1; tick(2);
    check("R8 rx blocked without carrier", {7'd0, rx_run_ok}, 8'd0);
    dcd_n = 1'b0;
    repeat (MIN_W + 2) @(posedge clk);
    @(negedge clk);
    check("R3 no change before latency", {6'd0, irq, stat_dcd}, 8'd0);
    @(posedge clk); @(negedge clk);
    check("R3 R4 irq and status at latency", {6'd0, irq, stat_dcd}, 8'b11);
    check("R8 rx runs with carrier", {7'd0, rx_run_ok}, 8'd1);

    // R5 status frozen while pending
    dcd_n = 1'b1; tick(MIN_W + 6);
    check("R5 status frozen while pending", {6'd0, irq, stat_dcd}, 8'b11);
    clear_status();
    check("R5 clear drops irq and reloads", {6'd0, irq, stat_dcd}, 8'b00);

    // R2 width sweep around the threshold
    for (int len = 1; len <= MIN_W + 2; len++) begin
      logic acc;
      acc = (len >= MIN_W);
      dcd_n = 1'b0; tick(len); dcd_n = 1'b1;
      tick(MIN_W + 6);
      check("R2 pulse width acceptance", {6'd0, irq, stat_dcd}, {6'd0, acc, acc});
      clear_status();
      check("R2 idle after pulse", {6'd0, irq, stat_dcd}, 8'd0);
    end

    // R4 R9 clear to send with transmitter auto-enable
    tx_auto_en = 1'b1; tick(2);
    check("R9 tx blocked without cts", {7'd0, tx_run_ok}, 8'd0);
    cts_n = 1'b0; tick(MIN_W + 6);
    check("R4 cts change raises irq", {6'd0, irq, stat_cts}, 8'b11);
    check("R9 tx runs with cts", {7'd0, tx_run_ok}, 8'd1);
    clear_status();
    cts_n = 1'b1; tick(MIN_W + 6);
    clear_status();
    check("R9 tx blocked after cts drop", {6'd0, tx_run_ok, stat_cts}, 8'd0);

    // R6 interrupts disabled
    int_en = 1'b0;
    dcd_n = 1'b0; tick(MIN_W + 6);
    check("R6 status follows without irq", {6'd0, irq, stat_dcd}, 8'b01);
    dcd_n = 1'b1; tick(MIN_W + 6);
    check("R6 status returns without irq", {6'd0, irq, stat_dcd}, 8'b00);
    int_en = 1'b1;

    // R7 sync line gated by mode
    mode_async = 1'b1; sync_n = 1'b0; tick(MIN_W + 6);
    check("R7 sync change in async mode", {6'd0, irq, stat_sync}, 8'b11);
    clear_status();
    sync_n = 1'b1; tick(MIN_W + 6);
    clear_status();
    mode_async = 1'b0; sync_n = 1'b0; tick(MIN_W + 6);
    check("R7 sync change in sync mode", {6'd0, irq, stat_sync}, 8'b01);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule